// File: doc/BRIEF.md
# Quad Register Prefix Decoder

This block sits in the opcode path of an 8-bit CPU front end. It receives one opcode byte per accepted cycle. For every byte it reports a decoded instruction: the base opcode, an addressing-mode code and a set of flags. The flags say whether the instruction runs in 32-bit quad mode, whether it is a reserved quad operation, and whether it uses a 32-bit flat pointer. In quad mode the four byte registers A, X, Y and Z act as one 32-bit register, with A as the least significant byte. That datapath lies outside this block; the decoder only tells the execution stages when to use it.

Quad mode is requested by two NEG opcode bytes (0x42) in a row, and it applies to the single instruction that follows them. The prefix bytes still run as ordinary instructions, since negating A twice has no net effect. A NOP byte (0xEA) placed directly before the NEG pair marks the coming instruction as a flat-pointer access. In quad mode only the Z-indexed zero-page indirect mode loses its index. It is reported as plain zero-page indirect, and under the flat marker it also raises the 32-bit pointer flag. Every X-indexed and Y-indexed mode, including those of the read-modify-write group, keeps its index.

Top module: `quad_prefix_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dec_valid_o`, `quad_o`, `rsvd_o` and `flat_ptr_o` are 0. Reset also cancels any partly received prefix.
- R2: A byte accepted while `byte_valid_i` is 1 produces `dec_valid_o`=1 in the next cycle, with `opcode_o` equal to that byte. A cycle with `byte_valid_i`=0 produces `dec_valid_o`=0.
- R3: The `mode_o` codes are: 0 other, 1 accumulator, 2 immediate, 3 zp, 4 zp,X, 5 abs, 6 abs,X, 7 abs,Y, 8 (zp,X), 9 (zp),Y, 10 (zp),Z, 11 (zp). For opcodes whose bits [1:0] are 01, bits [4:2] select, in order 0..7: (zp,X), zp, immediate, abs, (zp),Y, zp,X, abs,Y, abs,X.
- R4: Opcodes whose bits [4:0] are 10010 give (zp),Z. The shift/rotate/increment group has bits [1:0]=10 and bits [7:5] not 100 or 101. In that group, bits [4:2] of 001, 011, 101 and 111 give zp, abs, zp,X and abs,X. Bits [4:2]=010 gives accumulator, but only when bits [7:5] are at most 011. Every other opcode gives code 0.
- R5: The instruction after two consecutive 0x42 bytes has `quad_o`=1 if it has a quad form. An opcode has a quad form when R3 or R4 gives it a mode other than 0 or 2.
- R6: In quad mode, the (zp),Z mode is reported as (zp), code 11.
- R7: In quad mode, X-indexed and Y-indexed modes are reported unchanged, including in the shift/increment group.
- R8: Opcode 0x0A after the prefix gives `quad_o`=1 with accumulator mode, which means a 32-bit shift left of the quad register.
- R9: `flat_ptr_o`=1 only for a quad instruction in (zp),Z form that was preceded by the sequence 0xEA, 0x42, 0x42.
- R10: A prefixed opcode with no quad form gives `rsvd_o`=1 and `quad_o`=0, and its mode is decoded as if no prefix were present.
- R11: The prefix applies to exactly one instruction. Cycles without a valid byte do not change the prefix state.
- R12: The prefix bytes 0x42 and 0xEA decode as ordinary instructions, with `quad_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | An opcode byte is present |
| byte_i | input | 8 | Opcode byte |
| dec_valid_o | output | 1 | Decoded instruction is valid |
| opcode_o | output | 8 | Base opcode |
| mode_o | output | 4 | Addressing-mode code, after index suppression |
| quad_o | output | 1 | Instruction runs in 32-bit quad mode |
| rsvd_o | output | 1 | Prefix applied to an opcode with no quad form |
| flat_ptr_o | output | 1 | 32-bit flat pointer access |

## Verification
The bench builds the block with the default prefix codes 0x42 and 0xEA and with registered outputs. This lets it check every decoded field exactly one cycle after each byte. It sweeps all 256 opcodes in three contexts: with no prefix, after the NEG pair, and after the flat marker plus the NEG pair. That sweep covers every mode code, every reserved combination and every case where the index is dropped. Further runs insert idle cycles inside a prefix and assert reset in the middle of a prefix, to check that the prefix state holds while idle and that reset cancels it.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int OPC_W = 8;

  typedef enum logic [3:0] {
    AM_OTHER = 4'd0,
    AM_ACC   = 4'd1,
    AM_IMM   = 4'd2,
    AM_ZP    = 4'd3,
    AM_ZPX   = 4'd4,
    AM_ABS   = 4'd5,
    AM_ABSX  = 4'd6,
    AM_ABSY  = 4'd7,
    AM_IZX   = 4'd8,
    AM_IZY   = 4'd9,
    AM_IZZ   = 4'd10,
    AM_IZP   = 4'd11
  } am_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_FLAT = 2'd1,
    PS_NEG1 = 2'd2,
    PS_QUAD = 2'd3
  } pst_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    am_e              mode;
    logic             quad;
    logic             rsvd;
    logic             flat;
  } dec_t;
endpackage

// File: rtl/qpd_prefix_fsm.sv
module qpd_prefix_fsm
  import qpd_pkg::*;
#(
  parameter logic [OPC_W-1:0] NEG_OPC  = 8'h42,
  parameter logic [OPC_W-1:0] FLAT_OPC = 8'hEA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] byte_i,
  output logic             quad_act_o,
  output logic             flat_act_o
);
  pst_e state_q, state_d;
  logic flat_q, flat_d;

  always_comb begin
    state_d = state_q;
    flat_d  = flat_q;
    if (valid_i) begin
      if (state_q == PS_QUAD) begin
        // prefix is spent on this byte
        state_d = PS_IDLE;
        flat_d  = 1'b0;
      end else if (byte_i == NEG_OPC) begin
        if (state_q == PS_NEG1) begin
          state_d = PS_QUAD;
        end else begin
          state_d = PS_NEG1;
          flat_d  = (state_q == PS_FLAT);
        end
      end else if (byte_i == FLAT_OPC) begin
        state_d = PS_FLAT;
        flat_d  = 1'b0;
      end else begin
        state_d = PS_IDLE;
        flat_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      flat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flat_q  <= flat_d;
    end
  end

  assign quad_act_o = (state_q == PS_QUAD);
  assign flat_act_o = flat_q;

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state_q) && $stable(flat_q)));
  p_one_shot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q == PS_QUAD) |=> (state_q == PS_IDLE));
  p_flat_path_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flat_q |-> (state_q == PS_NEG1 || state_q == PS_QUAD));
endmodule

// File: rtl/qpd_classify.sv
module qpd_classify
  import qpd_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output am_e              mode_o,
  output logic             quad_cap_o
);
  logic [2:0] grp;
  logic [2:0] sel;
  logic [1:0] cls;
  logic       rmw_grp;

  assign grp     = opc_i[7:5];
  assign sel     = opc_i[4:2];
  assign cls     = opc_i[1:0];
  assign rmw_grp = (cls == 2'b10) && (grp != 3'b100) && (grp != 3'b101);

  always_comb begin
    mode_o = AM_OTHER;
    if (cls == 2'b01) begin
      unique case (sel)
        3'd0: mode_o = AM_IZX;
        3'd1: mode_o = AM_ZP;
        3'd2: mode_o = AM_IMM;
        3'd3: mode_o = AM_ABS;
        3'd4: mode_o = AM_IZY;
        3'd5: mode_o = AM_ZPX;
        3'd6: mode_o = AM_ABSY;
        default: mode_o = AM_ABSX;
      endcase
    end else if (opc_i[4:0] == 5'b10010) begin
      mode_o = AM_IZZ;
    end else if (rmw_grp) begin
      unique case (sel)
        3'd1: mode_o = AM_ZP;
        3'd3: mode_o = AM_ABS;
        3'd5: mode_o = AM_ZPX;
        3'd7: mode_o = AM_ABSX;
        3'd2: mode_o = (grp <= 3'd3) ? AM_ACC : AM_OTHER;
        default: mode_o = AM_OTHER;
      endcase
    end
  end

  // immediate operands have no 32-bit form
  assign quad_cap_o = (mode_o != AM_OTHER) && (mode_o != AM_IMM);
endmodule

// File: rtl/qpd_index_ctl.sv
module qpd_index_ctl
  import qpd_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  am_e              mode_i,
  input  logic             quad_cap_i,
  input  logic             quad_act_i,
  input  logic             flat_act_i,
  output dec_t             dec_o
);
  logic quad_ok;

  assign quad_ok = quad_act_i && quad_cap_i;

  always_comb begin
    dec_o.opc  = opc_i;
    dec_o.mode = mode_i;
    dec_o.quad = quad_ok;
    dec_o.rsvd = quad_act_i && !quad_cap_i;
    dec_o.flat = 1'b0;
    // only the Z index is dropped under quad mode
    if (quad_ok && mode_i == AM_IZZ) begin
      dec_o.mode = AM_IZP;
      dec_o.flat = flat_act_i;
    end
  end

  always_comb begin
    p_no_izz_r6: assert (!(dec_o.quad && dec_o.mode == AM_IZZ));
    p_keep_xy_r7: assert (!(dec_o.quad && mode_i != AM_IZZ) || dec_o.mode == mode_i);
  end
endmodule

// File: rtl/quad_prefix_decoder.sv
module quad_prefix_decoder
  import qpd_pkg::*;
#(
  parameter logic [7:0] NEG_OPC  = 8'h42,
  parameter logic [7:0] FLAT_OPC = 8'hEA,
  parameter bit         REG_OUT  = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       dec_valid_o,
  output logic [7:0] opcode_o,
  output logic [3:0] mode_o,
  output logic       quad_o,
  output logic       rsvd_o,
  output logic       flat_ptr_o
);
  logic quad_act, flat_act, quad_cap;
  am_e  raw_mode;
  dec_t dec;

  qpd_prefix_fsm #(.NEG_OPC(NEG_OPC), .FLAT_OPC(FLAT_OPC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (byte_valid_i),
    .byte_i     (byte_i),
    .quad_act_o (quad_act),
    .flat_act_o (flat_act)
  );

  qpd_classify u_cls (
    .opc_i      (byte_i),
    .mode_o     (raw_mode),
    .quad_cap_o (quad_cap)
  );

  qpd_index_ctl u_idx (
    .opc_i      (byte_i),
    .mode_i     (raw_mode),
    .quad_cap_i (quad_cap),
    .quad_act_i (quad_act),
    .flat_act_i (flat_act),
    .dec_o      (dec)
  );

  generate
    if (REG_OUT) begin : g_reg
      dec_t dec_q;
      logic vld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= 1'b0;
          dec_q <= '0;
        end else begin
          vld_q <= byte_valid_i;
          if (byte_valid_i) dec_q <= dec;
          else begin
            dec_q.quad <= 1'b0;
            dec_q.rsvd <= 1'b0;
            dec_q.flat <= 1'b0;
          end
        end
      end
      assign dec_valid_o = vld_q;
      assign opcode_o    = dec_q.opc;
      assign mode_o      = dec_q.mode;
      assign quad_o      = dec_q.quad;
      assign rsvd_o      = dec_q.rsvd;
      assign flat_ptr_o  = dec_q.flat;

      p_valid_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_i |=> dec_valid_o);
      p_opc_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_i |=> (opcode_o == $past(byte_i)));
    end else begin : g_comb
      assign dec_valid_o = byte_valid_i;
      assign opcode_o    = dec.opc;
      assign mode_o      = dec.mode;
      assign quad_o      = byte_valid_i && dec.quad;
      assign rsvd_o      = byte_valid_i && dec.rsvd;
      assign flat_ptr_o  = byte_valid_i && dec.flat;
    end
  endgenerate

  p_quad_rsvd_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(quad_o && rsvd_o));
  p_flat_needs_quad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flat_ptr_o |-> (quad_o && mode_o == 4'd11));
  p_flags_need_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_o || rsvd_o) |-> dec_valid_o);
endmodule

// File: tb/quad_prefix_decoder_test.sv
module quad_prefix_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0;
  logic [7:0] bi = 8'h00;
  logic       dv, qd, rs, fp;
  logic [7:0] op;
  logic [3:0] md;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench prefix model: 0 idle, 1 after EA, 2 after one 42, 3 armed
  int ms = 0;
  bit mflat = 0;

  always #4 clk = ~clk;

  quad_prefix_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bi),
    .dec_valid_o(dv), .opcode_o(op), .mode_o(md), .quad_o(qd),
    .rsvd_o(rs), .flat_ptr_o(fp)
  );

  function automatic int ref_mode(input int b);
    int lo2 = b % 4;
    int mid = (b / 4) % 8;
    int hi  = b / 32;
    int alu_tab[8] = '{8, 3, 2, 5, 9, 4, 7, 6};
    if (lo2 == 1) return alu_tab[mid];
    if ((b % 32) == 18) return 10;
    if (lo2 == 2 && hi != 4 && hi != 5) begin
      if (mid == 1) return 3;
      if (mid == 3) return 5;
      if (mid == 5) return 4;
      if (mid == 7) return 6;
      if (mid == 2 && hi <= 3) return 1;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int b);
    int m = ref_mode(b);
    bit cap = (m != 0) && (m != 2);
    bit armed = (ms == 3);
    bit eq = armed && cap;
    bit er = armed && !cap;
    int em = (eq && m == 10) ? 11 : m;
    bit ef = eq && (m == 10) && mflat;
    @(negedge clk);
    bv = 1'b1;
    bi = b[7:0];
    // advance model
    if (ms == 3) begin ms = 0; mflat = 0; end
    else if (b == 8'h42) begin
      if (ms == 2) ms = 3;
      else begin mflat = (ms == 1); ms = 2; end
    end else if (b == 8'hEA) begin ms = 1; mflat = 0; end
    else begin ms = 0; mflat = 0; end
    @(negedge clk);
    bv = 1'b0;
    chk(dv == 1'b1, "R2 valid", dv, 1);
    chk(op == b[7:0], "R2 opcode", op, b);
    if (eq && m == 10) chk(md == em[3:0], "R6 mode izz dropped", md, em);
    else if (eq && m != 1) chk(md == em[3:0], "R7 quad mode kept", md, em);
    else if (m == 10 || (b % 4) == 2) chk(md == em[3:0], "R4 mode", md, em);
    else chk(md == em[3:0], "R3 mode", md, em);
    if (b == 8'h0A && armed) chk(qd == 1'b1 && md == 4'd1, "R8 quad asl", qd, 1);
    else if (!armed && (b == 8'h42 || b == 8'hEA)) chk(qd == 1'b0, "R12 prefix byte plain", qd, 0);
    else chk(qd == eq, "R5 quad flag", qd, eq);
    chk(rs == er, "R10 reserved", rs, er);
    chk(fp == ef, "R9 flat pointer", fp, ef);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    bv = 1'b0;
    @(negedge clk);
    chk(dv == 1'b0, "R2 no valid when idle", dv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dv == 0 && qd == 0 && rs == 0 && fp == 0, "R1 reset outputs", {dv, qd, rs, fp}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dv == 0 && qd == 0 && rs == 0 && fp == 0, "R1 after reset", {dv, qd, rs, fp}, 0);

    for (int b = 0; b < 256; b++) send(b);
    send(8'h00);
    for (int b = 0; b < 256; b++) begin send(8'h42); send(8'h42); send(b); end
    for (int b = 0; b < 256; b++) begin send(8'hEA); send(8'h42); send(8'h42); send(b); end

    // R11: idle cycles inside a prefix keep the state
    send(8'hEA); idle_cycle(); send(8'h42); idle_cycle(); idle_cycle();
    send(8'h42); idle_cycle(); send(8'h12);
    chk(qd == 1'b1 && fp == 1'b1 && md == 4'd11, "R11 prefix held over idle", {qd, fp, md}, 6'h3B);
    // R11: one instruction only
    send(8'h42); send(8'h42); send(8'h52); send(8'h52);
    chk(qd == 1'b0 && md == 4'd10, "R11 prefix spent", {qd, md}, 10);
    // R9: flat marker separated from pair loses effect
    send(8'hEA); send(8'h00); send(8'h42); send(8'h42); send(8'hB2);
    chk(fp == 1'b0 && qd == 1'b1, "R9 no flat without marker", fp, 0);
    // R1: reset cancels a pending prefix
    send(8'h42); send(8'h42);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(dv == 0 && qd == 0, "R1 reset in prefix", {dv, qd}, 0);
    rst_n = 1'b1; ms = 0; mflat = 0;
    send(8'h12);
    chk(qd == 1'b0 && md == 4'd10, "R1 prefix cleared by reset", {qd, md}, 10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule